// File: doc/BRIEF.md
# Bayer Same-Color Defect Pixel Replacer

This block cleans isolated hot and dead pixels out of a raw Bayer pixel stream on the fly. Each pixel is compared with the two nearest pixels of its own color on the same line. In a Bayer mosaic those pixels are two columns to the left and two columns to the right, because the columns in between carry the other color. A pixel that stands out from both of these neighbors in the same direction by more than a programmable margin is treated as a defect. It is overwritten with the truncated mean of the two neighbors.

The stream carries a valid strobe together with start-of-line and end-of-line markers. The output keeps the same framing and accepts one pixel on every cycle. A pixel leaves the block one register after the pixel two positions behind it has been accepted, so the delay is counted in valid pixels and is unaffected by idle cycles. The margin is held in an internal register that is loaded through a write strobe. An enable input switches replacement on or off.

Top module: `bayer_defect_fix`

## Requirements
- R1: After reset `out_valid`, `out_sol`, `out_eol` and `out_pix` are all 0, and the threshold register holds 20.
- R2: While `cfg_enable` is 0, every pixel leaves the block with its input value unchanged.
- R3: With `cfg_enable` at 1, a pixel whose value minus each same-color neighbor is greater than the threshold is replaced by (left + right) >> 1, truncated. For example, 122 between neighbors 100 and 101 at threshold 20 becomes 100.
- R4: With `cfg_enable` at 1, a pixel that is lower than each same-color neighbor by more than the threshold is replaced by the same mean. The differences use signed arithmetic wider than the pixel, so a pixel of 0 between neighbors of 1023 becomes 1023.
- R5: A difference equal to the threshold does not count as an outlier; only a strictly greater difference does.
- R6: A pixel that lies above one neighbor and below the other is never replaced, however large the differences are.
- R7: The first two and the last two pixels of every line are always passed through unchanged, since each of them has a same-color neighbor on one side only.
- R8: Pixel k of the stream appears on the outputs in the cycle after the clock edge that accepts pixel k+2. `out_valid` is high for exactly one cycle per emitted pixel. `out_sol` and `out_eol` carry that pixel's own markers. No pixel is lost or duplicated, including when the input has idle cycles.
- R9: A cycle with `thr_wr` high loads `thr_data` into the threshold register, and pixels accepted afterwards are judged against the new value.
- R10: The comparison uses only the pixels at column offsets -2 and +2. The pixels at offsets -1 and +1 have no influence on the decision or on the replacement value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_enable | input | 1 | 1 = replace detected outliers, 0 = pass through |
| thr_wr | input | 1 | Load strobe for the threshold register |
| thr_data | input | 7 | New threshold value |
| in_valid | input | 1 | Input pixel strobe |
| in_sol | input | 1 | Input pixel is the first of its line |
| in_eol | input | 1 | Input pixel is the last of its line |
| in_pix | input | 10 | Input pixel value |
| out_valid | output | 1 | Output pixel strobe |
| out_sol | output | 1 | Output pixel is the first of its line |
| out_eol | output | 1 | Output pixel is the last of its line |
| out_pix | output | 10 | Output pixel value, replaced or passed through |

## Verification
Four properties are checked on every cycle:
- An output strobe always follows an accepted input one cycle earlier, and every accepted input that completes a window yields an output strobe.
- With the enable low, the output equals the held center pixel.
- A line's first pixel always leaves unaltered.
- Whenever a replacement is chosen, the emitted value differs from the original.

Some behaviour only shows up in the bench's scenarios because it depends on data values across several pixels:
- the exact mean and its truncation
- the strict threshold comparison
- the immunity to underflow
- ignoring the adjacent columns
- the default threshold and threshold reloads
- the exact latency when the input has idle gaps

// File: rtl/dpr_pkg.sv
package dpr_pkg;

   // Source chosen for an emitted pixel
   typedef enum logic {
      PICK_CENTER = 1'b0,
      PICK_MEAN   = 1'b1
   } dpr_pick_e;

   // Same-color spacing in a 2x2 mosaic
   localparam int BAYER_PITCH = 2;

endpackage

// File: rtl/dpr_thresh_reg.sv
module dpr_thresh_reg #(
   parameter int THR_W   = 7,
   parameter int THR_RST = 20
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic [THR_W-1:0] wdata,
   output logic [THR_W-1:0] thr
);

   localparam logic [THR_W-1:0] RST_VAL = THR_W'(THR_RST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         thr <= RST_VAL;
      end else if (wr) begin
         thr <= wdata;
      end
   end

endmodule

// File: rtl/dpr_window.sv
// Shift window of the last 2*DIST accepted pixels plus their line markers.
module dpr_window #(
   parameter int PIX_W = 10,
   parameter int DIST  = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             adv,
   input  logic [PIX_W-1:0] pix_in,
   input  logic             sol_in,
   input  logic             eol_in,
   output logic [PIX_W-1:0] mid_pix,
   output logic [PIX_W-1:0] far_pix,
   output logic             mid_fill,
   output logic             far_fill,
   output logic             mid_sol,
   output logic             mid_eol,
   output logic [DIST-1:0]  sol_left,
   output logic [DIST-1:0]  eol_right
);

   localparam int WIN  = 2 * DIST;
   localparam int SOLN = WIN - 1;

   logic [WIN-1:0][PIX_W-1:0] pix_q;
   logic [WIN-1:0]            fill_q;
   logic [SOLN-1:0]           sol_q;
   logic [DIST-1:0]           eol_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pix_q  <= '0;
         fill_q <= '0;
         sol_q  <= '0;
         eol_q  <= '0;
      end else if (adv) begin
         pix_q  <= {pix_q[WIN-2:0], pix_in};
         fill_q <= {fill_q[WIN-2:0], 1'b1};
         if (SOLN > 1) begin
            sol_q <= {sol_q[SOLN-2:0], sol_in};
         end else begin
            sol_q <= sol_in;
         end
         if (DIST > 1) begin
            eol_q <= {eol_q[DIST-2:0], eol_in};
         end else begin
            eol_q <= eol_in;
         end
      end
   end

   assign mid_pix   = pix_q[DIST-1];
   assign far_pix   = pix_q[WIN-1];
   assign mid_fill  = fill_q[DIST-1];
   assign far_fill  = fill_q[WIN-1];
   assign mid_sol   = sol_q[DIST-1];
   assign mid_eol   = eol_q[DIST-1];
   assign sol_left  = sol_q[SOLN-1:DIST-1];
   assign eol_right = eol_q;

endmodule

// File: rtl/dpr_judge.sv
// Outlier decision against two same-color neighbors and their mean.
module dpr_judge
   import dpr_pkg::*;
#(
   parameter int PIX_W = 10,
   parameter int THR_W = 7
) (
   input  logic [PIX_W-1:0] mid,
   input  logic [PIX_W-1:0] lft,
   input  logic [PIX_W-1:0] rgt,
   input  logic [THR_W-1:0] thr,
   input  logic             allow,
   output dpr_pick_e        pick,
   output logic [PIX_W-1:0] mean
);

   localparam int DW = PIX_W + 2;

   logic signed [DW-1:0] up_l, up_r, dn_l, dn_r, lim;
   logic [PIX_W:0]       sum;
   logic                 spike, pit;

   always_comb begin
      up_l  = $signed({2'b00, mid}) - $signed({2'b00, lft});
      up_r  = $signed({2'b00, mid}) - $signed({2'b00, rgt});
      dn_l  = -up_l;
      dn_r  = -up_r;
      lim   = $signed({{(DW-THR_W){1'b0}}, thr});
      spike = (up_l > lim) && (up_r > lim);
      pit   = (dn_l > lim) && (dn_r > lim);
      sum   = {1'b0, lft} + {1'b0, rgt};
      mean  = PIX_W'(sum >> 1);
      pick  = (allow && (spike || pit)) ? PICK_MEAN : PICK_CENTER;
   end

endmodule

// File: rtl/bayer_defect_fix.sv
module bayer_defect_fix
   import dpr_pkg::*;
#(
   parameter int PIX_W    = 10,
   parameter int THR_W    = 7,
   parameter int THR_RST  = 20,
   parameter int NBR_DIST = BAYER_PITCH
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_enable,
   input  logic             thr_wr,
   input  logic [THR_W-1:0] thr_data,
   input  logic             in_valid,
   input  logic             in_sol,
   input  logic             in_eol,
   input  logic [PIX_W-1:0] in_pix,
   output logic             out_valid,
   output logic             out_sol,
   output logic             out_eol,
   output logic [PIX_W-1:0] out_pix
);

   generate
      if (PIX_W < THR_W) begin : g_bad_width
         $error("bayer_defect_fix: THR_W must not exceed PIX_W");
      end
      if (NBR_DIST < 1) begin : g_bad_dist
         $error("bayer_defect_fix: NBR_DIST must be at least 1");
      end
      if (THR_RST < 0 || THR_RST >= (1 << THR_W)) begin : g_bad_rst
         $error("bayer_defect_fix: THR_RST does not fit in THR_W bits");
      end
   endgenerate

   logic [THR_W-1:0]    thr_cur;
   logic [PIX_W-1:0]    center_pix, left_pix, mean_pix;
   logic                center_fill, left_fill, center_sol, center_eol;
   logic [NBR_DIST-1:0] sol_left, eol_right;
   logic                inner;
   dpr_pick_e           pick;
   logic                fix_hit;

   dpr_thresh_reg #(
      .THR_W  (THR_W),
      .THR_RST(THR_RST)
   ) u_thr (
      .clk  (clk),
      .rst_n(rst_n),
      .wr   (thr_wr),
      .wdata(thr_data),
      .thr  (thr_cur)
   );

   dpr_window #(
      .PIX_W(PIX_W),
      .DIST (NBR_DIST)
   ) u_win (
      .clk      (clk),
      .rst_n    (rst_n),
      .adv      (in_valid),
      .pix_in   (in_pix),
      .sol_in   (in_sol),
      .eol_in   (in_eol),
      .mid_pix  (center_pix),
      .far_pix  (left_pix),
      .mid_fill (center_fill),
      .far_fill (left_fill),
      .mid_sol  (center_sol),
      .mid_eol  (center_eol),
      .sol_left (sol_left),
      .eol_right(eol_right)
   );

   // Both same-color neighbors sit on the center's own line
   assign inner = left_fill && center_fill && !(|sol_left) && !(|eol_right);

   dpr_judge #(
      .PIX_W(PIX_W),
      .THR_W(THR_W)
   ) u_judge (
      .mid  (center_pix),
      .lft  (left_pix),
      .rgt  (in_pix),
      .thr  (thr_cur),
      .allow(cfg_enable && inner),
      .pick (pick),
      .mean (mean_pix)
   );

   assign fix_hit = (pick == PICK_MEAN);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_sol   <= 1'b0;
         out_eol   <= 1'b0;
         out_pix   <= '0;
      end else begin
         out_valid <= in_valid && center_fill;
         if (in_valid) begin
            out_sol <= center_sol;
            out_eol <= center_eol;
            out_pix <= fix_hit ? mean_pix : center_pix;
         end
      end
   end

endmodule

// File: rtl/bayer_defect_fix_chk.sv
module bayer_defect_fix_chk #(
   parameter int PIX_W = 10
) (
   input logic             clk,
   input logic             rst_n,
   input logic             in_valid,
   input logic             cfg_enable,
   input logic             center_fill,
   input logic [PIX_W-1:0] center_pix,
   input logic             fix_hit,
   input logic             out_valid,
   input logic             out_sol,
   input logic [PIX_W-1:0] out_pix
);

   // R8
   strobe_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> $past(in_valid));

   // R8
   no_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(in_valid && center_fill) |-> out_valid);

   // R2
   bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !$past(cfg_enable)) |-> (out_pix == $past(center_pix)));

   // R7
   line_head_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_sol) |-> (out_pix == $past(center_pix)));

   // R3
   fix_changes_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(in_valid && fix_hit) |-> (out_pix != $past(center_pix)));

endmodule

bind bayer_defect_fix bayer_defect_fix_chk #(.PIX_W(PIX_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .in_valid   (in_valid),
   .cfg_enable (cfg_enable),
   .center_fill(center_fill),
   .center_pix (center_pix),
   .fix_hit    (fix_hit),
   .out_valid  (out_valid),
   .out_sol    (out_sol),
   .out_pix    (out_pix)
);

// File: tb/bayer_defect_fix_test.sv
module bayer_defect_fix_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cfg_enable = 1'b0;
   logic       thr_wr = 1'b0;
   logic [6:0] thr_data = '0;
   logic       in_valid = 1'b0;
   logic       in_sol = 1'b0;
   logic       in_eol = 1'b0;
   logic [9:0] in_pix = '0;
   logic       out_valid, out_sol, out_eol;
   logic [9:0] out_pix;

   always #5 clk = ~clk;

   bayer_defect_fix uut (
      .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .thr_wr(thr_wr),
      .thr_data(thr_data), .in_valid(in_valid), .in_sol(in_sol), .in_eol(in_eol),
      .in_pix(in_pix), .out_valid(out_valid), .out_sol(out_sol), .out_eol(out_eol),
      .out_pix(out_pix)
   );

   int          n_chk = 0;
   int          n_bad = 0;
   int          cur_thr = 20;
   bit          mon_en = 1'b0;
   bit          done = 1'b0;
   int          line_q[$];
   logic [11:0] got_q[$];
   logic [11:0] exp_q[$];
   string       tag_q[$];

   // {enable, threshold, left, center, right, expected center}
   localparam logic [47:0] VEC [14] = '{
      {1'b1, 7'd20,  10'd100,  10'd200,  10'd110,  10'd105},
      {1'b1, 7'd20,  10'd500,  10'd10,   10'd520,  10'd510},
      {1'b1, 7'd20,  10'd100,  10'd120,  10'd100,  10'd120},
      {1'b1, 7'd20,  10'd100,  10'd121,  10'd101,  10'd121},
      {1'b1, 7'd20,  10'd100,  10'd122,  10'd101,  10'd100},
      {1'b1, 7'd20,  10'd100,  10'd300,  10'd400,  10'd300},
      {1'b0, 7'd20,  10'd100,  10'd200,  10'd110,  10'd200},
      {1'b1, 7'd0,   10'd50,   10'd51,   10'd50,   10'd50},
      {1'b1, 7'd127, 10'd0,    10'd1023, 10'd0,    10'd0},
      {1'b1, 7'd127, 10'd1023, 10'd0,    10'd1023, 10'd1023},
      {1'b1, 7'd127, 10'd0,    10'd127,  10'd0,    10'd127},
      {1'b1, 7'd5,   10'd1023, 10'd1021, 10'd1014, 10'd1021},
      {1'b1, 7'd5,   10'd3,    10'd0,    10'd1,    10'd0},
      {1'b0, 7'd0,   10'd0,    10'd1023, 10'd0,    10'd1023}
   };
   string vec_tag [14];

   task automatic check(string req, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (mon_en && out_valid) got_q.push_back({out_pix, out_sol, out_eol});
   end

   task automatic push_expect(bit en, string req);
      int n;
      n = line_q.size();
      for (int i = 0; i < n; i++) begin
         int c;
         c = line_q[i];
         if (en && i >= 2 && i <= n - 3) begin
            int l, r;
            l = line_q[i-2];
            r = line_q[i+2];
            if ((c - l > cur_thr && c - r > cur_thr) || (l - c > cur_thr && r - c > cur_thr))
               c = (l + r) / 2;
         end
         exp_q.push_back({c[9:0], 1'(i == 0), 1'(i == n - 1)});
         tag_q.push_back(req);
      end
   endtask

   task automatic drive_line(int gap);
      int n;
      n = line_q.size();
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         in_valid = 1'b1;
         in_pix   = line_q[i][9:0];
         in_sol   = (i == 0);
         in_eol   = (i == n - 1);
         if (gap > 0 && (i % 3) == 1) begin
            @(negedge clk);
            in_valid = 1'b0;
         end
      end
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   task automatic send_line(bit en, string req, int gap);
      @(negedge clk);
      in_valid   = 1'b0;
      cfg_enable = en;
      push_expect(en, req);
      drive_line(gap);
   endtask

   task automatic write_thr(int t);
      @(negedge clk);
      in_valid = 1'b0;
      thr_wr   = 1'b1;
      thr_data = t[6:0];
      @(negedge clk);
      thr_wr   = 1'b0;
      cur_thr  = t;
   endtask

   task automatic finish_run();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      #2000000;
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual hung expected completion");
         finish_run();
      end
   end

   initial begin
      vec_tag = '{"R3", "R4", "R5", "R5", "R3", "R6", "R2",
                  "R5", "R3", "R4", "R5", "R6", "R5", "R2"};
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1 out_valid", out_valid, 0);
      check("R1 out_sol", out_sol, 0);
      check("R1 out_eol", out_eol, 0);
      check("R1 out_pix", out_pix, 0);
      mon_en = 1'b1;

      // R8 latency with an idle gap inside the line
      cfg_enable = 1'b1;
      line_q = '{11, 22, 33, 44, 55};
      push_expect(1'b1, "R8");
      @(negedge clk); in_valid = 1'b1; in_pix = 10'd11; in_sol = 1'b1; in_eol = 1'b0;
      @(negedge clk); check("R8 early strobe", out_valid, 0);
      in_pix = 10'd22; in_sol = 1'b0;
      @(negedge clk); check("R8 early strobe", out_valid, 0);
      in_valid = 1'b0;
      @(negedge clk); check("R8 idle strobe", out_valid, 0);
      in_valid = 1'b1; in_pix = 10'd33;
      @(negedge clk); check("R8 strobe", out_valid, 1);
      check("R8 first pixel", out_pix, 11);
      check("R8 sol", out_sol, 1);
      in_pix = 10'd44;
      @(negedge clk); check("R8 second pixel", out_pix, 22);
      in_pix = 10'd55; in_eol = 1'b1;
      @(negedge clk); in_valid = 1'b0; in_eol = 1'b0;

      // R1 default threshold of 20
      line_q = '{100, 0, 121, 0, 100};
      send_line(1'b1, "R1", 0);
      line_q = '{100, 0, 120, 0, 100};
      send_line(1'b1, "R1", 0);

      // R10 only the +-2 columns matter
      line_q = '{100, 300, 100, 300, 100};
      send_line(1'b1, "R10", 0);
      line_q = '{10, 500, 500, 500, 10};
      send_line(1'b1, "R10", 0);

      // R7 line edges and short lines
      line_q = '{900, 5, 10, 10, 10, 10, 900, 5};
      send_line(1'b1, "R7", 0);
      line_q = '{1023};
      send_line(1'b1, "R7", 0);
      line_q = '{0, 1023};
      send_line(1'b1, "R7", 0);
      line_q = '{0, 1023, 0};
      send_line(1'b1, "R7", 1);
      line_q = '{0, 0, 1023, 1023};
      send_line(1'b1, "R7", 0);

      // R3 and R4 on a long line with spikes, pits and idle gaps
      line_q = {};
      for (int i = 0; i < 40; i++) begin
         int v;
         v = (i * 37) % 90 + 300;
         if (i % 7 == 3) v = 1000;
         if (i % 11 == 5) v = 3;
         line_q.push_back(v);
      end
      send_line(1'b1, "R3", 1);

      // R9 threshold reload
      write_thr(50);
      line_q = '{100, 7, 140, 7, 100};
      send_line(1'b1, "R9", 0);
      write_thr(30);
      line_q = '{100, 7, 140, 7, 100};
      send_line(1'b1, "R9", 0);

      // Table of single-center vectors
      for (int k = 0; k < 14; k++) begin
         logic [47:0] v;
         v = VEC[k];
         write_thr(int'(v[46:40]));
         line_q = '{int'(v[39:30]), 600, int'(v[29:20]), 600, int'(v[19:10])};
         send_line(v[47], vec_tag[k], k % 2);
         exp_q[exp_q.size() - 3] = {v[9:0], 2'b00};
      end

      // R2 long spiky line with replacement disabled
      write_thr(0);
      line_q = {};
      for (int i = 0; i < 20; i++) line_q.push_back((i % 2 == 0) ? 1000 : 2);
      send_line(1'b0, "R2", 0);

      // flush the tail of the last line
      cfg_enable = 1'b0;
      line_q = '{0, 0};
      drive_line(0);
      repeat (5) @(negedge clk);
      mon_en = 1'b0;

      check("R8 pixel count", got_q.size(), exp_q.size());
      for (int i = 0; i < exp_q.size() && i < got_q.size(); i++) begin
         check({tag_q[i], " pixel"}, int'(got_q[i][11:2]), int'(exp_q[i][11:2]));
         check("R8 line markers", int'(got_q[i][1:0]), int'(exp_q[i][1:0]));
      end
      done = 1'b1;
      finish_run();
   end

endmodule